// File: doc/BRIEF.md
# Unified AES/Camellia Substitution Box

This block is a combinational byte substitution unit that serves two 128-bit block ciphers from one datapath. A 3-bit mode code selects the AES forward S-box, the AES inverse S-box, or one of the four Camellia S-boxes s1 to s4. Every mode shares a single multiplicative inverter that works in the tower field GF((2^4)^2). Each mode wraps that inverter in one combined linear map plus a constant on the input side, and another on the output side.

The combined maps merge three things: the field isomorphism between each cipher's native representation and the tower basis, the cipher's affine transforms, and the XOR constants. Each map is built at elaboration by constant functions from the defining polynomials. Bit rotations at the edges of the datapath give the Camellia s2, s3 and s4 variants. When the parameter `REG_OUT` is set, an output register adds one clock of latency.

Top module: `unified_sbox`

## Requirements
- R1: With mode 3'b000, the output is the AES forward S-box. The input is inverted in GF(2^8) modulo x^8+x^4+x^3+x+1, with 0 mapped to 0. The result b then becomes b ^ rotl(b,1) ^ rotl(b,2) ^ rotl(b,3) ^ rotl(b,4) ^ 8'h63. Example: 8'h53 gives 8'hED.
- R2: With mode 3'b001, the output is the AES inverse S-box. For every byte x, feeding the mode-000 output back in under mode 001 returns x.
- R3: With mode 3'b100, the output is Camellia s1(x) = H(inv(E(F(x ^ 8'hC5)))) ^ 8'h6E. Here F and H are the Camellia input and output bit mixes. E places bits 0..3 on α^0..α^3 and bits 4..7 on α^0·β..α^3·β. β is a root of x^8+x^6+x^5+x^3+1, α = β^238, and inv is inversion in that field. Examples: s1(00)=70, s1(01)=82, s1(02)=2C.
- R4: With mode 3'b101, the output is s1(x) rotated left by one bit.
- R5: With mode 3'b110, the output is s1(x) rotated right by one bit.
- R6: With mode 3'b111, the output is s1 applied to x rotated left by one bit.
- R7: Mode codes 3'b010 and 3'b011 produce 8'h00 for every input byte.
- R8: The field zero passes through the inverter as zero. So AES forward maps 8'h00 to 8'h63, and AES inverse maps 8'h63 to 8'h00.
- R9: With REG_OUT=1, the output changes one clock edge after the inputs. While the active-low reset is held, the output is 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| mode_i | input | 3 | Substitution mode code |
| din_i | input | 8 | Byte to substitute |
| dout_o | output | 8 | Substituted byte |

## Verification
The bench sweeps all 256 bytes in all eight mode codes against reference tables. It builds those tables with plain GF(2^8) arithmetic in each cipher's own polynomial basis, never in the tower basis. A wrong isomorphism or a misplaced affine constant would corrupt most entries of a whole mode, but the zero byte is the case that separates a mishandled constant (R8) from a mishandled inverter. It also checks published anchor values, so a reference that shares a misremembered bit mix with the design is still caught. The round trip through the forward and inverse AES modes would catch a reversed order of affine and inversion. The rotated Camellia modes are checked bit-exactly, which exposes a left/right or input/output swap of the rotation. The unused codes and the one-cycle latency are checked at the pins.

// File: rtl/usb_pkg.sv
package usb_pkg;

  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;

  // Tower field: GF(16) = GF(2)[z]/(z^4+z+1), extension y^2 + y + LAMBDA
  localparam logic [NIB_W-1:0]  GF16_RED  = 4'h3;   // z^4 = z + 1
  localparam logic [NIB_W-1:0]  TW_LAMBDA = 4'h8;   // z^3, trace one
  localparam logic [BYTE_W:0]   AES_POLY  = 9'h11B;
  localparam logic [BYTE_W:0]   CAM_POLY  = 9'h169;
  localparam int                CAM_ALPHA_EXP = 238;

  localparam logic [BYTE_W-1:0] AES_OUT_K = 8'h63;
  localparam logic [BYTE_W-1:0] CAM_IN_K  = 8'hC5;
  localparam logic [BYTE_W-1:0] CAM_OUT_K = 8'h6E;

  localparam logic [2:0] MODE_AES_FWD = 3'b000;
  localparam logic [2:0] MODE_AES_INV = 3'b001;
  localparam logic [2:0] MODE_CAM_S1  = 3'b100;
  localparam logic [2:0] MODE_CAM_S2  = 3'b101;
  localparam logic [2:0] MODE_CAM_S3  = 3'b110;
  localparam logic [2:0] MODE_CAM_S4  = 3'b111;

  typedef logic [BYTE_W-1:0][BYTE_W-1:0] mat8_t;  // m[j] = image of bit j

  typedef enum logic [1:0] {MAP_AES_FWD, MAP_AES_INV, MAP_CAM, MAP_NONE} map_e;
  typedef enum logic [1:0] {ROT_NONE, ROT_LEFT, ROT_RIGHT} rot_e;

  typedef struct packed {
    map_e map;
    logic in_rotl;
    rot_e out_rot;
    logic valid;
  } route_t;

  // ---------------- GF(16) ----------------
  function automatic logic [NIB_W-1:0] gf16_mul(logic [NIB_W-1:0] a, logic [NIB_W-1:0] b);
    logic [NIB_W-1:0] acc, sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < NIB_W; i++) begin
      if (b[i]) acc ^= sh;
      sh = {sh[NIB_W-2:0], 1'b0} ^ (sh[NIB_W-1] ? GF16_RED : '0);
    end
    return acc;
  endfunction

  // a^14 = a^-1 for nonzero a, and 0 for 0
  function automatic logic [NIB_W-1:0] gf16_inv(logic [NIB_W-1:0] a);
    logic [NIB_W-1:0] r;
    r = 4'h1;
    for (int i = 0; i < 14; i++) r = gf16_mul(r, a);
    return r;
  endfunction

  // ---------------- tower GF((2^4)^2) ----------------
  function automatic logic [BYTE_W-1:0] tw_mul(logic [BYTE_W-1:0] a, logic [BYTE_W-1:0] b);
    logic [NIB_W-1:0] hh, h, l;
    hh = gf16_mul(a[7:4], b[7:4]);
    h  = hh ^ gf16_mul(a[7:4], b[3:0]) ^ gf16_mul(a[3:0], b[7:4]);
    l  = gf16_mul(hh, TW_LAMBDA) ^ gf16_mul(a[3:0], b[3:0]);
    return {h, l};
  endfunction

  function automatic logic [BYTE_W-1:0] tw_eval(logic [BYTE_W-1:0] r, logic [BYTE_W:0] poly);
    logic [BYTE_W-1:0] acc, p;
    acc = '0;
    p   = 8'h01;
    for (int i = 0; i <= BYTE_W; i++) begin
      if (poly[i]) acc ^= p;
      p = tw_mul(p, r);
    end
    return acc;
  endfunction

  function automatic logic [BYTE_W-1:0] tw_find_root(logic [BYTE_W:0] poly);
    logic [BYTE_W-1:0] res;
    logic found;
    res   = '0;
    found = 1'b0;
    for (int k = 1; k < 256; k++) begin
      if (!found && tw_eval(8'(k), poly) == '0) begin
        res   = 8'(k);
        found = 1'b1;
      end
    end
    return res;
  endfunction

  // ---------------- polynomial-basis GF(2^8) ----------------
  function automatic logic [BYTE_W-1:0] gfp_mul(logic [BYTE_W-1:0] a, logic [BYTE_W-1:0] b,
                                                logic [BYTE_W:0] poly);
    logic [BYTE_W-1:0] acc, sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc ^= sh;
      sh = {sh[BYTE_W-2:0], 1'b0} ^ (sh[BYTE_W-1] ? poly[BYTE_W-1:0] : '0);
    end
    return acc;
  endfunction

  function automatic logic [BYTE_W-1:0] gfp_pow(logic [BYTE_W-1:0] a, int e, logic [BYTE_W:0] poly);
    logic [BYTE_W-1:0] r;
    r = 8'h01;
    for (int i = 0; i < e; i++) r = gfp_mul(r, a, poly);
    return r;
  endfunction

  // ---------------- GF(2) 8x8 matrices ----------------
  function automatic logic [BYTE_W-1:0] mat_apply(mat8_t m, logic [BYTE_W-1:0] x);
    logic [BYTE_W-1:0] y;
    y = '0;
    for (int j = 0; j < BYTE_W; j++) if (x[j]) y ^= m[j];
    return y;
  endfunction

  function automatic mat8_t mat_mul(mat8_t a, mat8_t b);
    mat8_t c;
    for (int j = 0; j < BYTE_W; j++) c[j] = mat_apply(a, b[j]);
    return c;
  endfunction

  // column i of the inverse is the preimage of unit vector i
  function automatic mat8_t mat_inv(mat8_t m);
    mat8_t r;
    r = '0;
    for (int i = 0; i < BYTE_W; i++)
      for (int v = 0; v < 256; v++)
        if (mat_apply(m, 8'(v)) == 8'(1 << i)) r[i] = 8'(v);
    return r;
  endfunction

  // polynomial basis x^i -> r^i in the tower field
  function automatic mat8_t mat_from_root(logic [BYTE_W-1:0] r);
    mat8_t m;
    logic [BYTE_W-1:0] p;
    p = 8'h01;
    for (int i = 0; i < BYTE_W; i++) begin
      m[i] = p;
      p    = tw_mul(p, r);
    end
    return m;
  endfunction

  function automatic logic [BYTE_W-1:0] aes_aff_lin(logic [BYTE_W-1:0] x);
    return x ^ {x[6:0], x[7]} ^ {x[5:0], x[7:6]} ^ {x[4:0], x[7:5]} ^ {x[3:0], x[7:4]};
  endfunction

  function automatic logic [BYTE_W-1:0] cam_f_lin(logic [BYTE_W-1:0] x);
    logic [BYTE_W-1:0] y;
    y[7] = x[2] ^ x[6];
    y[6] = x[1] ^ x[7];
    y[5] = x[0] ^ x[3] ^ x[5];
    y[4] = x[0] ^ x[5];
    y[3] = x[1] ^ x[4];
    y[2] = x[3] ^ x[6];
    y[1] = x[0] ^ x[7];
    y[0] = x[2] ^ x[4];
    return y;
  endfunction

  function automatic logic [BYTE_W-1:0] cam_h_lin(logic [BYTE_W-1:0] x);
    logic [BYTE_W-1:0] y;
    y[7] = x[2] ^ x[3] ^ x[6];
    y[6] = x[2] ^ x[6];
    y[5] = x[1] ^ x[4];
    y[4] = x[0] ^ x[6];
    y[3] = x[1] ^ x[5];
    y[2] = x[0] ^ x[7];
    y[1] = x[3] ^ x[7];
    y[0] = x[2] ^ x[5];
    return y;
  endfunction

  function automatic mat8_t mat_aes_aff();
    mat8_t m;
    for (int j = 0; j < BYTE_W; j++) m[j] = aes_aff_lin(8'(1 << j));
    return m;
  endfunction

  function automatic mat8_t mat_cam_f();
    mat8_t m;
    for (int j = 0; j < BYTE_W; j++) m[j] = cam_f_lin(8'(1 << j));
    return m;
  endfunction

  function automatic mat8_t mat_cam_h();
    mat8_t m;
    for (int j = 0; j < BYTE_W; j++) m[j] = cam_h_lin(8'(1 << j));
    return m;
  endfunction

  // Camellia bit vector -> element in polynomial basis of CAM_POLY
  function automatic mat8_t mat_cam_e();
    mat8_t m;
    logic [BYTE_W-1:0] alpha, ap;
    alpha = gfp_pow(8'h02, CAM_ALPHA_EXP, CAM_POLY);
    ap    = 8'h01;
    for (int i = 0; i < NIB_W; i++) begin
      m[i]         = ap;
      m[NIB_W + i] = gfp_mul(ap, 8'h02, CAM_POLY);
      ap           = gfp_mul(ap, alpha, CAM_POLY);
    end
    return m;
  endfunction

  // ---------------- combined per-mode maps ----------------
  localparam mat8_t ISO_AES     = mat_from_root(tw_find_root(AES_POLY));
  localparam mat8_t ISO_AES_INV = mat_inv(ISO_AES);
  localparam mat8_t ISO_CAM     = mat_from_root(tw_find_root(CAM_POLY));
  localparam mat8_t ISO_CAM_INV = mat_inv(ISO_CAM);
  localparam mat8_t AFF         = mat_aes_aff();
  localparam mat8_t AFF_INV     = mat_inv(AFF);
  localparam mat8_t CAM_E       = mat_cam_e();
  localparam mat8_t CAM_E_INV   = mat_inv(CAM_E);

  localparam mat8_t PRE_AES_FWD  = ISO_AES;
  localparam mat8_t PRE_AES_INV  = mat_mul(ISO_AES, AFF_INV);
  localparam mat8_t PRE_CAM      = mat_mul(ISO_CAM, mat_mul(CAM_E, mat_cam_f()));
  // A^-1 applied to the 0x63 offset is 0x05 before the basis change
  localparam logic [BYTE_W-1:0] PRE_AES_INV_K = mat_apply(PRE_AES_INV, AES_OUT_K);
  localparam logic [BYTE_W-1:0] PRE_CAM_K     = mat_apply(PRE_CAM, CAM_IN_K);

  localparam mat8_t POST_AES_FWD = mat_mul(AFF, ISO_AES_INV);
  localparam mat8_t POST_AES_INV = ISO_AES_INV;
  localparam mat8_t POST_CAM     = mat_mul(mat_cam_h(), mat_mul(CAM_E_INV, ISO_CAM_INV));

endpackage

// File: rtl/usb_mode_dec.sv
module usb_mode_dec
  import usb_pkg::*;
(
  input  logic [2:0] mode_i,
  output route_t     route_o
);
  always_comb begin
    route_o = '{map: MAP_NONE, in_rotl: 1'b0, out_rot: ROT_NONE, valid: 1'b0};
    case (mode_i)
      MODE_AES_FWD: begin route_o.map = MAP_AES_FWD; route_o.valid = 1'b1; end
      MODE_AES_INV: begin route_o.map = MAP_AES_INV; route_o.valid = 1'b1; end
      MODE_CAM_S1:  begin route_o.map = MAP_CAM; route_o.valid = 1'b1; end
      MODE_CAM_S2:  begin route_o.map = MAP_CAM; route_o.out_rot = ROT_LEFT;  route_o.valid = 1'b1; end
      MODE_CAM_S3:  begin route_o.map = MAP_CAM; route_o.out_rot = ROT_RIGHT; route_o.valid = 1'b1; end
      MODE_CAM_S4:  begin route_o.map = MAP_CAM; route_o.in_rotl = 1'b1;     route_o.valid = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/usb_premap.sv
module usb_premap
  import usb_pkg::*;
(
  input  map_e              map_i,
  input  logic              in_rotl_i,
  input  logic [BYTE_W-1:0] x_i,
  output logic [BYTE_W-1:0] t_o
);
  logic [BYTE_W-1:0] x_eff, c_aes_fwd, c_aes_inv, c_cam;

  assign x_eff     = in_rotl_i ? {x_i[BYTE_W-2:0], x_i[BYTE_W-1]} : x_i;
  assign c_aes_fwd = mat_apply(PRE_AES_FWD, x_eff);
  assign c_aes_inv = mat_apply(PRE_AES_INV, x_eff) ^ PRE_AES_INV_K;
  assign c_cam     = mat_apply(PRE_CAM, x_eff) ^ PRE_CAM_K;

  always_comb begin
    case (map_i)
      MAP_AES_FWD: t_o = c_aes_fwd;
      MAP_AES_INV: t_o = c_aes_inv;
      MAP_CAM:     t_o = c_cam;
      default:     t_o = '0;
    endcase
  end
endmodule

// File: rtl/usb_tower_inv.sv
module usb_tower_inv
  import usb_pkg::*;
(
  input  logic [BYTE_W-1:0] a_i,
  output logic [BYTE_W-1:0] inv_o
);
  logic [NIB_W-1:0] hi, lo, hi_sq_l, hl, lo_sq, delta, delta_inv;

  assign hi        = a_i[BYTE_W-1:NIB_W];
  assign lo        = a_i[NIB_W-1:0];
  assign hi_sq_l   = gf16_mul(gf16_mul(hi, hi), TW_LAMBDA);
  assign hl        = gf16_mul(hi, lo);
  assign lo_sq     = gf16_mul(lo, lo);
  assign delta     = hi_sq_l ^ hl ^ lo_sq;      // norm of the element
  assign delta_inv = gf16_inv(delta);
  assign inv_o     = {gf16_mul(hi, delta_inv), gf16_mul(hi ^ lo, delta_inv)};
endmodule

// File: rtl/usb_postmap.sv
module usb_postmap
  import usb_pkg::*;
(
  input  map_e              map_i,
  input  rot_e              out_rot_i,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] t_i,
  output logic [BYTE_W-1:0] y_o
);
  logic [BYTE_W-1:0] c_aes_fwd, c_aes_inv, c_cam, sel, rot;

  assign c_aes_fwd = mat_apply(POST_AES_FWD, t_i) ^ AES_OUT_K;
  assign c_aes_inv = mat_apply(POST_AES_INV, t_i);
  assign c_cam     = mat_apply(POST_CAM, t_i) ^ CAM_OUT_K;

  always_comb begin
    case (map_i)
      MAP_AES_FWD: sel = c_aes_fwd;
      MAP_AES_INV: sel = c_aes_inv;
      MAP_CAM:     sel = c_cam;
      default:     sel = '0;
    endcase
    case (out_rot_i)
      ROT_LEFT:  rot = {sel[BYTE_W-2:0], sel[BYTE_W-1]};
      ROT_RIGHT: rot = {sel[0], sel[BYTE_W-1:1]};
      default:   rot = sel;
    endcase
  end

  assign y_o = valid_i ? rot : '0;
endmodule

// File: rtl/unified_sbox.sv
module unified_sbox
  import usb_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_i,
  input  logic [BYTE_W-1:0] din_i,
  output logic [BYTE_W-1:0] dout_o
);
  route_t            route;
  logic              mode_ok;
  logic              out_registered;
  logic [BYTE_W-1:0] inv_in, inv_out, sbox_comb;

  assign mode_ok        = route.valid;
  assign out_registered = REG_OUT;

  usb_mode_dec u_dec (.mode_i(mode_i), .route_o(route));

  usb_premap u_pre (
    .map_i(route.map), .in_rotl_i(route.in_rotl), .x_i(din_i), .t_o(inv_in)
  );

  usb_tower_inv u_inv (.a_i(inv_in), .inv_o(inv_out));

  usb_postmap u_post (
    .map_i(route.map), .out_rot_i(route.out_rot), .valid_i(route.valid),
    .t_i(inv_out), .y_o(sbox_comb)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dout_o <= '0;
        else        dout_o <= sbox_comb;
      end
    end else begin : g_comb
      assign dout_o = sbox_comb;
    end
  endgenerate
endmodule

// File: rtl/unified_sbox_chk.sv
module unified_sbox_chk
  import usb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              out_registered,
  input logic [2:0]        mode_i,
  input logic [BYTE_W-1:0] din_i,
  input logic [BYTE_W-1:0] dout_o,
  input logic              mode_ok,
  input logic [BYTE_W-1:0] inv_in,
  input logic [BYTE_W-1:0] inv_out
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R1: the shared inverter returns a true multiplicative inverse
  p_inv_unity_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_in != '0) |-> (tw_mul(inv_in, inv_out) == 8'h01));

  // R8: field zero passes the inverter as zero
  p_inv_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_in == '0) |-> (inv_out == '0));

  // R8: AES forward of 0x00 is 0x63
  p_aes_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_registered && mode_i == MODE_AES_FWD && din_i == '0) |=> (dout_o == 8'h63));

  // R7: unused codes give zero (registered and combinational variants)
  p_bad_mode_reg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_registered && !mode_ok) |=> (dout_o == '0));
  p_bad_mode_comb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_registered && !mode_ok) |-> (dout_o == '0));

  // R9: steady inputs give a steady output one edge later
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_registered && armed && $stable(mode_i) && $stable(din_i)) |=> $stable(dout_o));

  // R9: output cleared while reset is held
  p_reset_r9: assert property (@(posedge clk)
    (out_registered && !rst_n) |-> (dout_o == '0));
endmodule

bind unified_sbox unified_sbox_chk u_chk (
  .clk(clk), .rst_n(rst_n), .out_registered(out_registered),
  .mode_i(mode_i), .din_i(din_i), .dout_o(dout_o), .mode_ok(mode_ok),
  .inv_in(inv_in), .inv_out(inv_out)
);

// File: tb/unified_sbox_bench.sv
module unified_sbox_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode = 3'b000;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] aes_tab [256];
  logic [7:0] aes_itab [256];
  logic [7:0] cam_tab [256];
  logic [7:0] e_tab [256];
  logic [7:0] e_itab [256];
  logic [7:0] fmask [8];
  logic [7:0] hmask [8];

  always #2 clk = ~clk;   // 250 MHz

  unified_sbox u_unified_sbox (.clk(clk), .rst_n(rst_n), .mode_i(mode), .din_i(din), .dout_o(dout));

  function automatic logic [7:0] gm(logic [7:0] a, logic [7:0] b, logic [8:0] p);
    logic [15:0] prod;
    prod = '0;
    for (int i = 0; i < 8; i++) if (b[i]) prod ^= 16'(a) << i;
    for (int i = 15; i >= 8; i--) if (prod[i]) prod ^= 16'(p) << (i - 8);
    return prod[7:0];
  endfunction

  function automatic logic [7:0] ginv(logic [7:0] a, logic [8:0] p);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 0; i < 254; i++) r = gm(r, a, p);
    return r;
  endfunction

  function automatic logic [7:0] rl(logic [7:0] v, int n);
    return 8'((16'(v) << n) | (16'(v) >> (8 - n)));
  endfunction

  function automatic logic [7:0] par_map(logic [7:0] x, logic [7:0] m [8]);
    logic [7:0] y;
    for (int k = 0; k < 8; k++) y[k] = ^(x & m[k]);
    return y;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] m, input logic [7:0] x, output logic [7:0] y);
    @(negedge clk);
    mode = m;
    din  = x;
    @(negedge clk);
    y = dout;
  endtask

  function automatic logic [7:0] expect_of(logic [2:0] m, logic [7:0] x);
    case (m)
      3'b000: return aes_tab[x];
      3'b001: return aes_itab[x];
      3'b100: return cam_tab[x];
      3'b101: return rl(cam_tab[x], 1);
      3'b110: return rl(cam_tab[x], 7);
      3'b111: return cam_tab[rl(x, 1)];
      default: return 8'h00;
    endcase
  endfunction

  function automatic string req_of(logic [2:0] m);
    case (m)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b100: return "R3";
      3'b101: return "R4";
      3'b110: return "R5";
      3'b111: return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] y, z, b, alpha;
    logic [7:0] basis [8];
    fmask = '{8'h14, 8'h81, 8'h48, 8'h12, 8'h21, 8'h29, 8'h82, 8'h44};
    hmask = '{8'h24, 8'h88, 8'h81, 8'h22, 8'h41, 8'h12, 8'h44, 8'h4C};
    for (int x = 0; x < 256; x++) begin
      b = ginv(8'(x), 9'h11B);
      aes_tab[x] = b ^ rl(b, 1) ^ rl(b, 2) ^ rl(b, 3) ^ rl(b, 4) ^ 8'h63;
    end
    for (int x = 0; x < 256; x++) aes_itab[aes_tab[x]] = 8'(x);
    alpha = 8'h6C;
    basis[0] = 8'h01;
    for (int i = 1; i < 4; i++) basis[i] = gm(basis[i-1], alpha, 9'h169);
    for (int i = 0; i < 4; i++) basis[4+i] = gm(basis[i], 8'h02, 9'h169);
    for (int c = 0; c < 256; c++) begin
      b = '0;
      for (int i = 0; i < 8; i++) if (c[i]) b ^= basis[i];
      e_tab[c] = b;
    end
    for (int c = 0; c < 256; c++) e_itab[e_tab[c]] = 8'(c);
    for (int x = 0; x < 256; x++)
      cam_tab[x] = par_map(e_itab[ginv(e_tab[par_map(8'(x) ^ 8'hC5, fmask)], 9'h169)], hmask) ^ 8'h6E;

    // R9: reset state
    repeat (3) @(negedge clk);
    chk("R9 reset", dout, 8'h00);
    rst_n = 1'b1;

    // anchors from the published tables
    run(3'b000, 8'h00, y); chk("R8 aes(00)", y, 8'h63);
    run(3'b000, 8'h53, y); chk("R1 aes(53)", y, 8'hED);
    run(3'b000, 8'h01, y); chk("R1 aes(01)", y, 8'h7C);
    run(3'b001, 8'h63, y); chk("R8 aesinv(63)", y, 8'h00);
    run(3'b001, 8'hED, y); chk("R2 aesinv(ED)", y, 8'h53);
    run(3'b100, 8'h00, y); chk("R3 s1(00)", y, 8'h70);
    run(3'b100, 8'h01, y); chk("R3 s1(01)", y, 8'h82);
    run(3'b100, 8'h02, y); chk("R3 s1(02)", y, 8'h2C);

    // R9: latency of exactly one edge
    @(negedge clk); mode = 3'b000; din = 8'h53;
    #1; chk("R9 before edge", dout, 8'h2C);
    @(negedge clk); chk("R9 after edge", dout, 8'hED);

    // full sweep, all codes (R1..R7)
    for (int m = 0; m < 8; m++)
      for (int x = 0; x < 256; x++) begin
        run(3'(m), 8'(x), y);
        chk(req_of(3'(m)), y, expect_of(3'(m), 8'(x)));
      end

    // R2: inverse undoes forward
    for (int x = 0; x < 256; x++) begin
      run(3'b000, 8'(x), y);
      run(3'b001, y, z);
      chk("R2 roundtrip", z, 8'(x));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule